// File: doc/BRIEF.md
# Page Write Load Controller

This block sits behind an asynchronous byte-wide memory write port whose strobes (active-low chip select, write strobe and read enable) are sampled in one clock domain. It collects host byte writes into a page of up to 2^OFFS_W bytes and then runs a self-timed programming period. The low OFFS_W address bits pick the byte inside the page. The remaining upper bits pick the page.

A write is qualified only while chip select and write strobe are both low and read enable is high. The address is taken when that condition begins, which is the later of the two falling edges. The data is taken on the last sampled cycle before it ends, which is the earlier of the two rising edges. The load window has no fixed length. Every accepted strobe in the latched page restarts a byte-load timeout. Programming starts once that timeout runs out with no newer accepted strobe.

The controller has three states:
- ST_IDLE moves to ST_LOAD on the first accepted strobe.
- ST_LOAD stays in ST_LOAD on each accepted strobe in the same page, which restarts the timeout. It moves to ST_PROG when the timeout expires and no byte is pending.
- ST_PROG moves back to ST_IDLE when the programming timer expires.

Top module: `pgload_ctrl`

## Requirements
- R1: After reset, busy and load_open are 0, byte_valid is all zero, and page_addr, last_addr and last_data are 0.
- R2: While the window is open, a strobe whose upper address bits differ from page_addr is discarded. It leaves byte_valid, last_addr and last_data unchanged and does not restart the timeout. page_addr stays fixed while the window is open.
- R3: The first accepted strobe opens the window (load_open=1). Each accepted same-page strobe that starts within TLOAD_CYC cycles of the previous one keeps it open. busy rises between TLOAD_CYC and TLOAD_CYC+GLITCH_CYC+10 cycles after the write strobe of the last accepted byte goes low, and only straight from an open window.
- R4: The committed address is the bus address on the first cycle where chip select and write strobe are both low. The committed data is the bus data on the last such cycle. Changes after either edge are ignored. This holds whether the write strobe or the chip select makes the last falling edge.
- R5: No byte is taken while read enable is low, while chip select is high, or while the write strobe is high.
- R6: A qualified strobe that lasts fewer than GLITCH_CYC sampled cycles is ignored. A strobe that lasts exactly GLITCH_CYC cycles is accepted.
- R7: busy stays high for exactly TPROG_CYC cycles. The block then returns to idle with busy and load_open both 0.
- R8: Strobes while busy is high are ignored. byte_valid, last_addr and last_data stay unchanged, and no new window opens afterwards.
- R9: byte_valid bit i is set when a byte at page offset i is committed. The mask only grows while the window is open and is cleared when the next page operation starts. last_addr and last_data hold the final committed byte.
- R10: page_addr equals the upper address bits (bit OFFS_W and above) of the first accepted byte of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Active-low chip select |
| wr_strobe_n | input | 1 | Active-low write strobe |
| rd_enable_n | input | 1 | Active-low read enable; low blocks writes |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| busy | output | 1 | Programming period in progress |
| load_open | output | 1 | Page load window open |
| page_addr | output | ADDR_W-OFFS_W | Latched page address |
| byte_valid | output | 2^OFFS_W | Per-offset loaded mask |
| last_addr | output | ADDR_W | Address of last committed byte |
| last_data | output | DATA_W | Data of last committed byte |

## Verification
The bench builds the block with a 6-bit address and 8-byte pages (OFFS_W=3). It uses a 40-cycle byte-load timeout, a 3-cycle glitch filter and a 25-cycle programming period. These small values let it sweep every page length from one to eight bytes, with the offsets in permuted orders. Expected masks, data and page numbers are computed arithmetically. The short timers also put the timeout edge, the exact programming length, the glitch threshold (two cycles rejected, three accepted) and strobes during programming within a few thousand cycles.

// File: rtl/pgload_pkg.sv
package pgload_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pgl_state_e;

    function automatic int unsigned pgl_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgload_sync.sv
module pgload_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pgload_strobe.sv
module pgload_strobe #(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              re_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              acc,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              done,
    output logic [ADDR_W-1:0] done_addr,
    output logic [DATA_W-1:0] done_data
);

    localparam int GW = $clog2(GLITCH_CYC + 1);

    logic              act;
    logic              act_q;
    logic              taken_q;
    logic [GW-1:0]     gcnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // qualified write condition: select and strobe low, read enable high
    assign act       = !cs_n && !we_n && re_n;
    assign acc       = act && (gcnt_q == GW'(GLITCH_CYC - 1));
    assign acc_addr  = (act && !act_q) ? addr : addr_q;
    assign done      = !act && act_q && taken_q;
    assign done_addr = addr_q;
    assign done_data = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            taken_q <= 1'b0;
            gcnt_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) addr_q <= addr;       // later falling edge
            if (act)           data_q <= data;       // held from last active cycle
            if (!act)
                gcnt_q <= '0;
            else if (gcnt_q != GW'(GLITCH_CYC))
                gcnt_q <= gcnt_q + 1'b1;
            if (!act)     taken_q <= 1'b0;
            else if (acc) taken_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pgload_timer.sv
module pgload_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgload_ctrl.sv
module pgload_ctrl
    import pgload_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int OFFS_W     = 8,
    parameter int DATA_W     = 8,
    parameter int TLOAD_CYC  = 10000,
    parameter int GLITCH_CYC = 2,
    parameter int TPROG_CYC  = 1000000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        chip_sel_n,
    input  logic                        wr_strobe_n,
    input  logic                        rd_enable_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic                        busy,
    output logic                        load_open,
    output logic [ADDR_W-OFFS_W-1:0]    page_addr,
    output logic [(1<<OFFS_W)-1:0]      byte_valid,
    output logic [ADDR_W-1:0]           last_addr,
    output logic [DATA_W-1:0]           last_data
);

    localparam int PAGE_W     = ADDR_W - OFFS_W;
    localparam int PAGE_BYTES = 1 << OFFS_W;
    localparam int BUS_W      = 3 + ADDR_W + DATA_W;
    localparam int TW         = $clog2(pgl_max(TLOAD_CYC, TPROG_CYC) + 1);
    localparam logic [BUS_W-1:0] BUS_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    // sampled port bundle
    logic [BUS_W-1:0]  bus_raw;
    logic [BUS_W-1:0]  bus_s;
    logic              cs_s, we_s, re_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;

    assign bus_raw = {chip_sel_n, wr_strobe_n, rd_enable_n, bus_addr, bus_wdata};
    assign {cs_s, we_s, re_s, addr_s, data_s} = bus_s;

    pgload_sync #(
        .WIDTH   (BUS_W),
        .STAGES  (2),
        .RST_VAL (BUS_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .q     (bus_s)
    );

    // strobe qualification
    logic              acc;
    logic [ADDR_W-1:0] acc_addr;
    logic              done;
    logic [ADDR_W-1:0] done_addr;
    logic [DATA_W-1:0] done_data;

    pgload_strobe #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .GLITCH_CYC (GLITCH_CYC)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_s),
        .we_n      (we_s),
        .re_n      (re_s),
        .addr      (addr_s),
        .data      (data_s),
        .acc       (acc),
        .acc_addr  (acc_addr),
        .done      (done),
        .done_addr (done_addr),
        .done_data (done_data)
    );

    // shared window / programming timer
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    pgload_timer #(
        .WIDTH (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // state and datapath registers
    pgl_state_e             state_q, state_d;
    logic [PAGE_W-1:0]      page_q;
    logic [PAGE_BYTES-1:0]  mask_q;
    logic [ADDR_W-1:0]      last_addr_q;
    logic [DATA_W-1:0]      last_data_q;
    logic                   pend_q;
    logic                   page_hit;
    logic [OFFS_W-1:0]      done_off;

    assign page_hit = (acc_addr[ADDR_W-1:OFFS_W] == page_q);
    assign done_off = done_addr[OFFS_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (acc) begin
                    state_d  = ST_LOAD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TLOAD_CYC);
                end
            end
            ST_LOAD: begin
                if (acc && page_hit) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TLOAD_CYC);
                end else if (tmr_zero && !pend_q && !acc) begin
                    state_d  = ST_PROG;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TPROG_CYC - 1);
                end
            end
            ST_PROG: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q == ST_PROG);
        load_open  = (state_q == ST_LOAD);
        page_addr  = page_q;
        byte_valid = mask_q;
        last_addr  = last_addr_q;
        last_data  = last_data_q;
    end

    // page capture, byte commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q      <= '0;
            mask_q      <= '0;
            last_addr_q <= '0;
            last_data_q <= '0;
            pend_q      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && acc) begin
                page_q <= acc_addr[ADDR_W-1:OFFS_W];
                mask_q <= '0;
                pend_q <= 1'b1;
            end else if (state_q == ST_LOAD && acc) begin
                pend_q <= page_hit;
            end else if (done) begin
                if (pend_q) begin
                    mask_q[done_off] <= 1'b1;
                    last_addr_q      <= done_addr;
                    last_data_q      <= done_data;
                end
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pgload_chk.sv
module pgload_chk #(
    parameter int ADDR_W    = 17,
    parameter int OFFS_W    = 8,
    parameter int DATA_W    = 8,
    parameter int TPROG_CYC = 1000000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     load_open,
    input logic [ADDR_W-OFFS_W-1:0] page_addr,
    input logic [(1<<OFFS_W)-1:0]   byte_valid,
    input logic [ADDR_W-1:0]        last_addr,
    input logic [DATA_W-1:0]        last_data
);

    localparam int CW = $clog2(TPROG_CYC + 2);

    logic [CW-1:0] bcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        bcnt_q <= '0;
        else if (!busy)                    bcnt_q <= '0;
        else if (bcnt_q != CW'(TPROG_CYC)) bcnt_q <= bcnt_q + 1'b1;
    end

    AST_PROG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt_q < CW'(TPROG_CYC)));  // R7
    AST_PROG_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(bcnt_q) == CW'(TPROG_CYC - 1)));  // R7
    AST_BUSY_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load_open));  // R3
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_open && $past(load_open)) |-> $stable(page_addr));  // R2
    AST_LAST_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((load_open || busy) && (|byte_valid)) |-> (last_addr[ADDR_W-1:OFFS_W] == page_addr));  // R2
    AST_MASK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_open && $past(load_open)) |-> (($past(byte_valid) & ~byte_valid) == '0));  // R9
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_open |-> $stable(byte_valid));  // R8
    AST_LAST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load_open |-> ($stable(last_addr) && $stable(last_data)));  // R8

endmodule

bind pgload_ctrl pgload_chk #(
    .ADDR_W    (ADDR_W),
    .OFFS_W    (OFFS_W),
    .DATA_W    (DATA_W),
    .TPROG_CYC (TPROG_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .load_open  (load_open),
    .page_addr  (page_addr),
    .byte_valid (byte_valid),
    .last_addr  (last_addr),
    .last_data  (last_data)
);

// File: tb/pgload_ctrl_bench.sv
module pgload_ctrl_bench;

    localparam int AW = 6;
    localparam int OW = 3;
    localparam int DW = 8;
    localparam int TL = 40;
    localparam int GL = 3;
    localparam int TP = 25;
    localparam int PB = 1 << OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, we_n = 1'b1, rd_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          busy, load_open;
    logic [AW-OW-1:0] page_addr;
    logic [PB-1:0] byte_valid;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;

    always #5 clk = ~clk;

    pgload_ctrl #(
        .ADDR_W(AW), .OFFS_W(OW), .DATA_W(DW),
        .TLOAD_CYC(TL), .GLITCH_CYC(GL), .TPROG_CYC(TP)
    ) u_pgload_ctrl (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(cs_n), .wr_strobe_n(we_n),
        .rd_enable_n(rd_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .load_open(load_open), .page_addr(page_addr),
        .byte_valid(byte_valid), .last_addr(last_addr), .last_data(last_data)
    );

    int     n_chk = 0, n_fail = 0;
    bit     finished = 1'b0;
    longint cyc = 0;
    longint last_start = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wbyte(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int mode, input int len);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; rd_n = 1'b1;
        if (mode == 0) begin cs_n = 1'b0; @(negedge clk); we_n = 1'b0; end
        else           begin we_n = 1'b0; @(negedge clk); cs_n = 1'b0; end
        last_start = cyc;
        repeat (len) @(negedge clk);
        if (mode == 0) begin we_n = 1'b1; @(negedge clk); cs_n = 1'b1; end
        else           begin cs_n = 1'b1; @(negedge clk); we_n = 1'b1; end
        @(negedge clk);
    endtask

    task automatic wait_rise(output longint rise);
        rise = -1;
        for (int i = 0; i < 400 && rise < 0; i++) begin
            @(negedge clk);
            if (busy) rise = cyc;
        end
    endtask

    task automatic prog_len(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic check_rise(input string tag, input longint rise, input longint ref_start);
        longint rel;
        rel = rise - ref_start;
        check(rise >= 0 && rel >= TL && rel <= TL + GL + 10, tag,
              "busy rise delay after last accepted strobe", rel, TL + GL);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [PB-1:0] em;
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        longint        rise, s0;
        int            plen;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && load_open == 0, "R1", "busy/open after reset", {busy, load_open}, 0);
        check(byte_valid == 0 && page_addr == 0, "R1", "mask/page after reset", byte_valid, 0);
        check(last_addr == 0 && last_data == 0, "R1", "last addr/data after reset", last_addr, 0);

        // sweep page lengths 1..PB with permuted offsets (R9, R10, R7, R3)
        for (int n = 1; n <= PB; n++) begin
            int pg;
            pg = (n * 3) % PB;
            em = '0;
            for (int k = 0; k < n; k++) begin
                int off;
                off = (n * 3 + k * 5) % PB;
                ea  = AW'(pg * PB + off);
                ed  = DW'(pg * 16 + off * 7 + n);
                wbyte(ea, ed, k % 2, GL + 1);
                em[off] = 1'b1;
                if (k == 0) check(load_open == 1, "R3", "window open after first byte", load_open, 1);
            end
            repeat (2) @(negedge clk);
            check(byte_valid == em, "R9", "mask after page load", byte_valid, em);
            check(last_addr == ea && last_data == ed, "R9", "last byte", {last_addr, last_data}, {ea, ed});
            check(page_addr == pg[AW-OW-1:0], "R10", "page address", page_addr, pg);
            wait_rise(rise);
            check_rise("R3", rise, last_start);
            prog_len(plen);
            check(plen == TP, "R7", "busy length", plen, TP);
            check(busy == 0 && load_open == 0, "R7", "idle after programming", {busy, load_open}, 0);
        end

        // R3 window extended by strobes spaced below the timeout
        wbyte(AW'(1 * PB + 0), 8'hA0, 0, GL + 1);
        for (int j = 1; j < 4; j++) begin
            repeat (22) @(negedge clk);
            check(busy == 0 && load_open == 1, "R3", "window still open inside timeout", {busy, load_open}, 1);
            wbyte(AW'(1 * PB + j), DW'(8'hA0 + j), j % 2, GL + 1);
        end
        wait_rise(rise);
        check_rise("R3", rise, last_start);
        check(byte_valid == 8'h0F, "R3", "mask after extended window", byte_valid, 8'h0F);
        prog_len(plen);

        // R2 byte of another page discarded, timeout not restarted
        wbyte(AW'(2 * PB + 1), 8'h5A, 0, GL + 1);
        s0 = last_start;
        repeat (12) @(negedge clk);
        wbyte(AW'(5 * PB + 3), 8'hC3, 1, GL + 1);
        repeat (2) @(negedge clk);
        check(byte_valid == 8'h02, "R2", "mask after foreign page byte", byte_valid, 8'h02);
        check(last_addr == AW'(2 * PB + 1) && last_data == 8'h5A, "R2", "last byte after foreign page",
              {last_addr, last_data}, {AW'(2 * PB + 1), 8'h5A});
        check(page_addr == 3'd2, "R2", "page held", page_addr, 2);
        wait_rise(rise);
        check_rise("R2", rise, s0);
        prog_len(plen);

        // R4 write-strobe-controlled capture
        @(negedge clk);
        bus_addr = AW'(4 * PB + 2); bus_wdata = 8'h11; rd_n = 1'b1; cs_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (2) @(negedge clk); bus_addr = AW'(4 * PB + 6); bus_wdata = 8'h22;
        repeat (2) @(negedge clk); bus_wdata = 8'h33;
        repeat (2) @(negedge clk); we_n = 1'b1;
        @(negedge clk); bus_wdata = 8'h44; cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(last_addr == AW'(4 * PB + 2), "R4", "address at later falling edge", last_addr, 4 * PB + 2);
        check(last_data == 8'h33, "R4", "data before first rising edge", last_data, 8'h33);
        // R4 chip-select-controlled capture
        bus_addr = AW'(4 * PB + 5); bus_wdata = 8'h55; we_n = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk); bus_addr = AW'(4 * PB + 0); bus_wdata = 8'h66;
        repeat (2) @(negedge clk); cs_n = 1'b1;
        @(negedge clk); bus_wdata = 8'h77; we_n = 1'b1;
        repeat (4) @(negedge clk);
        check(last_addr == AW'(4 * PB + 5) && last_data == 8'h66, "R4", "select-controlled capture",
              {last_addr, last_data}, {AW'(4 * PB + 5), 8'h66});
        check(byte_valid == 8'h24, "R4", "mask for captured offsets", byte_valid, 8'h24);
        wait_rise(rise);
        prog_len(plen);

        // R5 blocked combinations
        ea = last_addr;
        @(negedge clk); bus_addr = AW'(6 * PB + 1); rd_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
        repeat (8) @(negedge clk); we_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
        repeat (6) @(negedge clk);
        check(load_open == 0 && last_addr == ea, "R5", "read enable low blocks write", load_open, 0);
        cs_n = 1'b1; we_n = 1'b0;
        repeat (8) @(negedge clk); we_n = 1'b1;
        repeat (6) @(negedge clk);
        check(load_open == 0 && last_addr == ea, "R5", "chip select high blocks write", load_open, 0);
        cs_n = 1'b0;
        repeat (8) @(negedge clk); cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(load_open == 0 && busy == 0, "R5", "write strobe high blocks write", {busy, load_open}, 0);

        // R6 glitch filter threshold
        wbyte(AW'(7 * PB + 4), 8'hE1, 0, GL - 1);
        repeat (6) @(negedge clk);
        check(load_open == 0 && last_addr == ea, "R6", "short strobe ignored", load_open, 0);
        wbyte(AW'(7 * PB + 4), 8'hE2, 1, GL);
        repeat (2) @(negedge clk);
        check(load_open == 1, "R6", "minimum strobe accepted", load_open, 1);
        check(last_data == 8'hE2 && byte_valid == 8'h10, "R6", "minimum strobe committed", last_data, 8'hE2);

        // R8 strobes during programming ignored
        wait_rise(rise);
        wbyte(AW'(7 * PB + 1), 8'h99, 0, GL + 2);
        while (busy) @(negedge clk);
        check(last_addr == AW'(7 * PB + 4) && last_data == 8'hE2, "R8", "last byte unchanged by busy write",
              {last_addr, last_data}, {AW'(7 * PB + 4), 8'hE2});
        check(byte_valid == 8'h10, "R8", "mask unchanged by busy write", byte_valid, 8'h10);
        repeat (TL + 20) @(negedge clk);
        check(busy == 0 && load_open == 0, "R8", "no window after busy write", {busy, load_open}, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule